// File: doc/BRIEF.md
# Two-Level Distributed Event Counter

This block is a performance counting fabric. Several local monitors each watch a small group of attached nodes. Each node drives a bus of single-cycle event pulses. Every local monitor also carries two flit watchpoints that compare passing traffic against a programmable value under a mask. Each monitor holds a few narrow local counters. A local counter counts a chosen node event or a watchpoint hit. It can count across every attached node, or only the one node that it names.

The local counters are narrow. When a local counter wraps, the wrap is sent in the same cycle to one of the wide global counters in a shared central controller. A per-counter index field picks which global counter receives it. The controller has the global enable, the clear mask and a free-running cycle counter. When a global counter overflows, it sets a sticky status bit that drives an interrupt. Two watchpoints can be paired so that together they produce one combined event.

Software programs the block through a simple register port. Writes take effect on the next rising clock edge, and reads are combinational.

Top module: `perf_fabric`

## Requirements
- R1: After reset, every counter, every configuration field, the enable bit, the status bits and `irq` are all zero.
- R2: A local counter whose config has bit0 = 0 (node source) and bit1 = 0 (aggregate) adds, on each enabled cycle, the number of attached nodes that assert the event line chosen by config bits [5:2].
- R3: When config bit1 = 1 (by-node), the counter adds only the selected line of the node numbered in config bits [9:6]. Pulses from the other nodes are ignored.
- R4: A local counter is 16 bits wide and wraps from 0xFFFF past zero. Each wrap adds one to the global counter named in config bits [12:10]. Wraps from several local counters that reach the same global counter in one cycle are all added.
- R5: A global counter is 32 bits wide. When it wraps, the status bit with its index is set (status at 0x01). `irq` is high while any status bit is set. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R6: The cycle counter (0x02) adds one on every cycle while the enable bit (0x00 bit0) is set, whatever the events and counter configs are. Any write to 0x02 zeroes it.
- R7: A watchpoint reads the flit stream for the direction in its config bit0 (0 = upload, 1 = download). It hits when that stream is valid and the flit equals the match value in every bit where the mask is 0. A local counter with config bit0 = 1 counts hits of watchpoint config bit2 (0 or 1).
- R8: When both watchpoints of a monitor have the same nonzero tag (watchpoint config bits [2:1]), they form one event. That event fires only when both hit in the same cycle, and it is credited to watchpoint 0; watchpoint 1 then produces nothing. A zero tag, or two different tags, makes them count independently.
- R9: Writing a mask to 0x03 zeroes each global counter whose bit is set. A wrap that reaches such a counter in the same cycle is dropped.
- R10: While the enable bit is 0, no local counter and the cycle counter do not change except through register writes.

Register layout: global counter g at 0x10+g; config of local counter c in monitor m at 0x20+4m+c; its value (writable) at 0x40+4m+c; for watchpoint w of monitor m, match value at 0x60+8m+4w, mask at +1, config at +2. A write of a global counter or local value loads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| node_evt | input | N_MON*N_NODE*EV_W | Event pulses, monitor-major, then node, then line |
| flit_up_vld | input | N_MON | Upload flit valid per monitor |
| flit_up_dat | input | N_MON*FW | Upload flit data per monitor |
| flit_dn_vld | input | N_MON | Download flit valid per monitor |
| flit_dn_dat | input | N_MON*FW | Download flit data per monitor |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| irq | output | 1 | Global overflow interrupt |

## Verification
A table of node-event patterns is applied to one counter. It uses one node, both nodes, lines next to the chosen one, and all lines at once, with both aggregate and by-node selection. This separates a correct popcount and node filter from one that ORs the nodes together or ignores the node field. Wrap tests preload counters just below their limit. They separate two local wraps landing on one global counter in the same cycle from a single wrap, and a double increment that crosses zero from a plain increment. Watchpoint flits differ only in masked bits, only in unmasked bits, or only in direction. Paired watchpoints are driven with one hit and then with both hits, which shows whether the combine rule and its credit to watchpoint 0 are honoured. A clear that coincides with a wrap shows whether the dropped wrap really disappears.

// File: rtl/perf_pkg.sv
package perf_pkg;

   localparam int REG_AW = 8;
   localparam int REG_DW = 32;

   localparam logic [REG_AW-1:0] ADR_CTRL = 8'h00;
   localparam logic [REG_AW-1:0] ADR_STAT = 8'h01;
   localparam logic [REG_AW-1:0] ADR_CYC  = 8'h02;
   localparam logic [REG_AW-1:0] ADR_CLR  = 8'h03;
   localparam logic [REG_AW-1:0] ADR_GLB  = 8'h10;
   localparam logic [REG_AW-1:0] ADR_LCFG = 8'h20;
   localparam logic [REG_AW-1:0] ADR_LVAL = 8'h40;
   localparam logic [REG_AW-1:0] ADR_WP   = 8'h60;

   typedef enum logic {
      SRC_NODE  = 1'b0,
      SRC_WATCH = 1'b1
   } src_e;

   // local counter configuration, bit0 is src
   typedef struct packed {
      logic [2:0] gidx;
      logic [3:0] node;
      logic [3:0] evt;
      logic       bynode;
      src_e       src;
   } lcfg_t;

   localparam int LCFG_W = $bits(lcfg_t);

   // watchpoint configuration, bit0 is direction
   typedef struct packed {
      logic [1:0] tag;
      logic       dir;
   } wcfg_t;

   localparam int WCFG_W = $bits(wcfg_t);

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/pf_watchpoint.sv
module pf_watchpoint
   import perf_pkg::*;
#(
   parameter int FW = 16,
   parameter int WD = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_val,
   input  logic          we_mask,
   input  logic          we_cfg,
   input  logic [WD-1:0] wdata,
   input  logic          up_vld,
   input  logic [FW-1:0] up_dat,
   input  logic          dn_vld,
   input  logic [FW-1:0] dn_dat,
   output logic          hit,
   output logic [FW-1:0] val_o,
   output logic [FW-1:0] mask_o,
   output wcfg_t         cfg_o
);

   logic [FW-1:0] val_q;
   logic [FW-1:0] mask_q;
   wcfg_t         cfg_q;
   logic          sel_vld;
   logic [FW-1:0] sel_dat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_q  <= '0;
         mask_q <= '0;
         cfg_q  <= '0;
      end else begin
         if (we_val)  val_q  <= wdata[FW-1:0];
         if (we_mask) mask_q <= wdata[FW-1:0];
         if (we_cfg)  cfg_q  <= wcfg_t'(wdata[WCFG_W-1:0]);
      end
   end

   always_comb begin
      sel_vld = cfg_q.dir ? dn_vld : up_vld;
      sel_dat = cfg_q.dir ? dn_dat : up_dat;
      hit     = sel_vld && (((sel_dat ^ val_q) & ~mask_q) == '0);
   end

   assign val_o  = val_q;
   assign mask_o = mask_q;
   assign cfg_o  = cfg_q;

endmodule

// File: rtl/pf_local_monitor.sv
module pf_local_monitor
   import perf_pkg::*;
#(
   parameter int N_CNT  = 4,
   parameter int N_NODE = 2,
   parameter int EV_W   = 8,
   parameter int LW     = 16,
   parameter int FW     = 16,
   parameter int WD     = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          en,
   input  logic [N_NODE*EV_W-1:0]        node_evt,
   input  logic                          up_vld,
   input  logic [FW-1:0]                 up_dat,
   input  logic                          dn_vld,
   input  logic [FW-1:0]                 dn_dat,
   input  logic [N_CNT-1:0]              cfg_we,
   input  logic [N_CNT-1:0]              val_we,
   input  logic [5:0]                    wp_we,
   input  logic [WD-1:0]                 wdata,
   output logic [N_CNT-1:0]              wrap,
   output lcfg_t [N_CNT-1:0]             cfg_o,
   output logic [N_CNT-1:0][LW-1:0]      cnt_o,
   output logic [1:0][FW-1:0]            wval_o,
   output logic [1:0][FW-1:0]            wmask_o,
   output wcfg_t [1:0]                   wcfg_o
);

   localparam int IW   = $clog2(N_NODE + 1);
   localparam int N_WP = 2;

   logic [N_WP-1:0] hit;
   logic [N_WP-1:0] wev;
   logic            paired;

   for (genvar w = 0; w < N_WP; w++) begin : g_wp
      pf_watchpoint #(.FW(FW), .WD(WD)) u_wp (
         .clk     (clk),
         .rst_n   (rst_n),
         .we_val  (wp_we[w*3]),
         .we_mask (wp_we[w*3+1]),
         .we_cfg  (wp_we[w*3+2]),
         .wdata   (wdata),
         .up_vld  (up_vld),
         .up_dat  (up_dat),
         .dn_vld  (dn_vld),
         .dn_dat  (dn_dat),
         .hit     (hit[w]),
         .val_o   (wval_o[w]),
         .mask_o  (wmask_o[w]),
         .cfg_o   (wcfg_o[w])
      );
   end

   // equal nonzero tags fuse both watchpoints into one event on slot 0
   assign paired = (wcfg_o[0].tag != 2'b00) && (wcfg_o[0].tag == wcfg_o[1].tag);
   assign wev[0] = paired ? (hit[0] & hit[1]) : hit[0];
   assign wev[1] = paired ? 1'b0 : hit[1];

   for (genvar c = 0; c < N_CNT; c++) begin : g_cnt
      lcfg_t         cfg_q;
      logic [LW-1:0] cnt_q;
      logic [IW-1:0] inc;
      logic [LW:0]   sum;

      always_comb begin
         inc = '0;
         if (cfg_q.src == SRC_WATCH) begin
            inc = IW'(wev[cfg_q.evt[0]]);
         end else begin
            for (int n = 0; n < N_NODE; n++) begin
               if (!cfg_q.bynode || (int'(cfg_q.node) == n)) begin
                  for (int e = 0; e < EV_W; e++) begin
                     if ((int'(cfg_q.evt) == e) && node_evt[n*EV_W+e]) inc = inc + 1'b1;
                  end
               end
            end
         end
         sum = {1'b0, cnt_q} + (LW+1)'(inc);
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_q <= '0;
            cnt_q <= '0;
         end else begin
            if (cfg_we[c]) cfg_q <= lcfg_t'(wdata[LCFG_W-1:0]);
            if (val_we[c])  cnt_q <= wdata[LW-1:0];
            else if (en)    cnt_q <= sum[LW-1:0];
         end
      end

      assign wrap[c]  = en && !val_we[c] && sum[LW];
      assign cfg_o[c] = cfg_q;
      assign cnt_o[c] = cnt_q;
   end

endmodule

// File: rtl/pf_central.sv
module pf_central
   import perf_pkg::*;
#(
   parameter int N_GLB = 8,
   parameter int GW    = 32,
   parameter int N_SRC = 8,
   parameter int CYC_W = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       en,
   input  logic [N_SRC-1:0]           wrap,
   input  logic [N_SRC-1:0][2:0]      gidx,
   input  logic [N_GLB-1:0]           clr,
   input  logic [N_GLB-1:0]           glb_we,
   input  logic [N_GLB-1:0]           stat_w1c,
   input  logic                       cyc_clr,
   input  logic [GW-1:0]              wdata,
   output logic [N_GLB-1:0][GW-1:0]   glb_o,
   output logic [N_GLB-1:0]           stat_o,
   output logic [CYC_W-1:0]           cyc_o,
   output logic                       irq
);

   localparam int SW = $clog2(N_SRC + 1);

   logic [N_GLB-1:0] ovf;
   logic [N_GLB-1:0] stat_q;
   logic [CYC_W-1:0] cyc_q;

   for (genvar g = 0; g < N_GLB; g++) begin : g_glb
      logic [SW-1:0] inc;
      logic [GW:0]   sum;
      logic [GW-1:0] q;

      always_comb begin
         inc = '0;
         for (int i = 0; i < N_SRC; i++) begin
            if (wrap[i] && (int'(gidx[i]) == g)) inc = inc + 1'b1;
         end
         sum = {1'b0, q} + (GW+1)'(inc);
      end

      // clear beats load beats wrap accumulation
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          q <= '0;
         else if (clr[g])     q <= '0;
         else if (glb_we[g])  q <= wdata;
         else                 q <= sum[GW-1:0];
      end

      assign ovf[g]   = !clr[g] && !glb_we[g] && sum[GW];
      assign glb_o[g] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~stat_w1c) | ovf;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cyc_q <= '0;
      else if (cyc_clr) cyc_q <= '0;
      else if (en)      cyc_q <= cyc_q + 1'b1;
   end

   assign stat_o = stat_q;
   assign cyc_o  = cyc_q;
   assign irq    = |stat_q;

endmodule

// File: rtl/perf_fabric.sv
module perf_fabric
   import perf_pkg::*;
#(
   parameter int N_MON  = 2,
   parameter int N_CNT  = 4,
   parameter int N_NODE = 2,
   parameter int EV_W   = 8,
   parameter int LW     = 16,
   parameter int N_GLB  = 8,
   parameter int GW     = 32,
   parameter int FW     = 16,
   parameter int CYC_W  = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [N_MON*N_NODE*EV_W-1:0]  node_evt,
   input  logic [N_MON-1:0]              flit_up_vld,
   input  logic [N_MON*FW-1:0]           flit_up_dat,
   input  logic [N_MON-1:0]              flit_dn_vld,
   input  logic [N_MON*FW-1:0]           flit_dn_dat,
   input  logic                          reg_we,
   input  logic [REG_AW-1:0]             reg_addr,
   input  logic [REG_DW-1:0]             reg_wdata,
   output logic [REG_DW-1:0]             reg_rdata,
   output logic                          irq
);

   localparam int N_SRC = N_MON * N_CNT;
   localparam int NE    = N_NODE * EV_W;
   localparam int WD    = max3(LW, LCFG_W, FW);

   if (N_CNT < 1 || N_CNT > 4)     begin : g_bad_cnt  $error("N_CNT must be 1..4");   end
   if (N_GLB < 1 || N_GLB > 8)     begin : g_bad_glb  $error("N_GLB must be 1..8");   end
   if (N_MON < 1 || N_MON > 4)     begin : g_bad_mon  $error("N_MON must be 1..4");   end
   if (N_NODE < 1 || N_NODE > 16)  begin : g_bad_node $error("N_NODE must be 1..16"); end
   if (EV_W < 1 || EV_W > 16)      begin : g_bad_evw  $error("EV_W must be 1..16");   end
   if (LW < 2 || LW > REG_DW)      begin : g_bad_lw   $error("LW out of range");      end
   if (GW < 2 || GW > REG_DW)      begin : g_bad_gw   $error("GW out of range");      end
   if (FW < WCFG_W || FW > REG_DW) begin : g_bad_fw   $error("FW out of range");      end
   if (CYC_W < 1 || CYC_W > REG_DW) begin : g_bad_cyc $error("CYC_W out of range");   end
   if (GW < N_GLB)                 begin : g_bad_mask $error("GW must cover N_GLB");  end

   logic                              en_q;
   logic [N_GLB-1:0]                  clr;
   logic [N_GLB-1:0]                  glb_we;
   logic [N_GLB-1:0]                  stat_w1c;
   logic                              cyc_clr;
   logic [N_SRC-1:0]                  wrap;
   logic [N_SRC-1:0][2:0]             gidx;
   logic [N_GLB-1:0][GW-1:0]          glb_v;
   logic [N_GLB-1:0]                  stat_w;
   logic [CYC_W-1:0]                  cyc_w;
   logic [N_MON-1:0][N_CNT-1:0][LW-1:0] lcnt;
   lcfg_t [N_MON-1:0][N_CNT-1:0]      lcfg;
   logic [N_MON-1:0][1:0][FW-1:0]     wval;
   logic [N_MON-1:0][1:0][FW-1:0]     wmask;
   wcfg_t [N_MON-1:0][1:0]            wcfg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else if (reg_we && (reg_addr == ADR_CTRL)) en_q <= reg_wdata[0];
   end

   always_comb begin
      cyc_clr = reg_we && (reg_addr == ADR_CYC);
      for (int g = 0; g < N_GLB; g++) begin
         clr[g]      = reg_we && (reg_addr == ADR_CLR) && reg_wdata[g];
         stat_w1c[g] = reg_we && (reg_addr == ADR_STAT) && reg_wdata[g];
         glb_we[g]   = reg_we && (reg_addr == (ADR_GLB + REG_AW'(g)));
      end
   end

   for (genvar m = 0; m < N_MON; m++) begin : g_mon
      logic [N_CNT-1:0] cfg_we;
      logic [N_CNT-1:0] val_we;
      logic [5:0]       wp_we;

      always_comb begin
         for (int c = 0; c < N_CNT; c++) begin
            cfg_we[c] = reg_we && (reg_addr == (ADR_LCFG + REG_AW'(m*4 + c)));
            val_we[c] = reg_we && (reg_addr == (ADR_LVAL + REG_AW'(m*4 + c)));
         end
         for (int w = 0; w < 2; w++) begin
            for (int k = 0; k < 3; k++) begin
               wp_we[w*3+k] = reg_we && (reg_addr == (ADR_WP + REG_AW'(m*8 + w*4 + k)));
            end
         end
      end

      pf_local_monitor #(
         .N_CNT (N_CNT),
         .N_NODE(N_NODE),
         .EV_W  (EV_W),
         .LW    (LW),
         .FW    (FW),
         .WD    (WD)
      ) u_mon (
         .clk      (clk),
         .rst_n    (rst_n),
         .en       (en_q),
         .node_evt (node_evt[m*NE +: NE]),
         .up_vld   (flit_up_vld[m]),
         .up_dat   (flit_up_dat[m*FW +: FW]),
         .dn_vld   (flit_dn_vld[m]),
         .dn_dat   (flit_dn_dat[m*FW +: FW]),
         .cfg_we   (cfg_we),
         .val_we   (val_we),
         .wp_we    (wp_we),
         .wdata    (reg_wdata[WD-1:0]),
         .wrap     (wrap[m*N_CNT +: N_CNT]),
         .cfg_o    (lcfg[m]),
         .cnt_o    (lcnt[m]),
         .wval_o   (wval[m]),
         .wmask_o  (wmask[m]),
         .wcfg_o   (wcfg[m])
      );

      for (genvar c = 0; c < N_CNT; c++) begin : g_idx
         assign gidx[m*N_CNT+c] = lcfg[m][c].gidx;
      end
   end

   pf_central #(
      .N_GLB (N_GLB),
      .GW    (GW),
      .N_SRC (N_SRC),
      .CYC_W (CYC_W)
   ) u_central (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en_q),
      .wrap     (wrap),
      .gidx     (gidx),
      .clr      (clr),
      .glb_we   (glb_we),
      .stat_w1c (stat_w1c),
      .cyc_clr  (cyc_clr),
      .wdata    (reg_wdata[GW-1:0]),
      .glb_o    (glb_v),
      .stat_o   (stat_w),
      .cyc_o    (cyc_w),
      .irq      (irq)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADR_CTRL) reg_rdata[0] = en_q;
      if (reg_addr == ADR_STAT) reg_rdata[N_GLB-1:0] = stat_w;
      if (reg_addr == ADR_CYC)  reg_rdata[CYC_W-1:0] = cyc_w;
      for (int g = 0; g < N_GLB; g++) begin
         if (reg_addr == (ADR_GLB + REG_AW'(g))) reg_rdata[GW-1:0] = glb_v[g];
      end
      for (int m = 0; m < N_MON; m++) begin
         for (int c = 0; c < N_CNT; c++) begin
            if (reg_addr == (ADR_LCFG + REG_AW'(m*4 + c))) reg_rdata[LCFG_W-1:0] = lcfg[m][c];
            if (reg_addr == (ADR_LVAL + REG_AW'(m*4 + c))) reg_rdata[LW-1:0] = lcnt[m][c];
         end
         for (int w = 0; w < 2; w++) begin
            if (reg_addr == (ADR_WP + REG_AW'(m*8 + w*4)))     reg_rdata[FW-1:0] = wval[m][w];
            if (reg_addr == (ADR_WP + REG_AW'(m*8 + w*4 + 1))) reg_rdata[FW-1:0] = wmask[m][w];
            if (reg_addr == (ADR_WP + REG_AW'(m*8 + w*4 + 2))) reg_rdata[WCFG_W-1:0] = wcfg[m][w];
         end
      end
   end

endmodule

// File: rtl/perf_fabric_chk.sv
module perf_fabric_chk
   import perf_pkg::*;
#(
   parameter int N_GLB = 8,
   parameter int CYC_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [REG_AW-1:0] reg_addr,
   input logic              irq,
   input logic              en,
   input logic [N_GLB-1:0]  stat,
   input logic [CYC_W-1:0]  cyc
);

   logic stat_wr;
   logic cyc_wr;

   assign stat_wr = reg_we && (reg_addr == ADR_STAT);
   assign cyc_wr  = reg_we && (reg_addr == ADR_CYC);

   // R1: reset leaves interrupt, status and cycle count at zero
   assert_reset_clean_R1: assert property (@(posedge clk)
      !rst_n |=> (!irq && (stat == '0) && (cyc == '0)));

   // R5: the interrupt stays up until software writes the status register
   assert_irq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !stat_wr) |=> irq);

   // R5: status bits are sticky without a status write
   assert_stat_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_wr |=> ((stat & $past(stat)) == $past(stat)));

   // R6: enabled cycle counter advances by exactly one
   assert_cyc_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !cyc_wr) |=> (cyc == CYC_W'($past(cyc) + 1'b1)));

   // R10: disabled cycle counter holds
   assert_cyc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !cyc_wr) |=> $stable(cyc));

endmodule

bind perf_fabric perf_fabric_chk #(
   .N_GLB (N_GLB),
   .CYC_W (CYC_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_we   (reg_we),
   .reg_addr (reg_addr),
   .irq      (irq),
   .en       (en_q),
   .stat     (stat_w),
   .cyc      (cyc_w)
);

// File: tb/test_perf_fabric.sv
module test_perf_fabric;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] node_evt = '0;
   logic [1:0]  flit_up_vld = '0;
   logic [31:0] flit_up_dat = '0;
   logic [1:0]  flit_dn_vld = '0;
   logic [31:0] flit_dn_dat = '0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   perf_fabric i_perf_fabric (
      .clk         (clk),
      .rst_n       (rst_n),
      .node_evt    (node_evt),
      .flit_up_vld (flit_up_vld),
      .flit_up_dat (flit_up_dat),
      .flit_dn_vld (flit_dn_vld),
      .flit_dn_dat (flit_dn_dat),
      .reg_we      (reg_we),
      .reg_addr    (reg_addr),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .irq         (irq)
   );

   // {cfg[15:0], node pattern of monitor 0 [15:0], expected increment[7:0]}
   localparam logic [39:0] VEC [7] = '{
      {16'h000C, 16'h0808, 8'd2},
      {16'h000C, 16'h0800, 8'd1},
      {16'h004E, 16'h0808, 8'd1},
      {16'h0016, 16'h2000, 8'd0},
      {16'h0000, 16'h0002, 8'd0},
      {16'h001E, 16'h0080, 8'd1},
      {16'h001C, 16'hFFFF, 8'd2}
   };

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   task automatic pulse(input logic [31:0] p);
      @(negedge clk);
      node_evt = p;
      @(negedge clk);
      node_evt = '0;
   endtask

   task automatic flit(input logic uv, input logic [15:0] ud, input logic dv, input logic [15:0] dd);
      @(negedge clk);
      flit_up_vld[0] = uv; flit_up_dat[15:0] = ud;
      flit_dn_vld[0] = dv; flit_dn_dat[15:0] = dd;
      @(negedge clk);
      flit_up_vld = '0; flit_dn_vld = '0;
   endtask

   initial begin
      #(CLK_PERIOD*50000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog all-requirements actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      rd(8'h00, v); chk("R1 ctrl", v, 0);
      rd(8'h01, v); chk("R1 status", v, 0);
      rd(8'h02, v); chk("R1 cycle", v, 0);
      rd(8'h10, v); chk("R1 global0", v, 0);
      rd(8'h40, v); chk("R1 local m0c0", v, 0);
      rd(8'h20, v); chk("R1 cfg m0c0", v, 0);
      chk("R1 irq", {31'b0, irq}, 0);

      // R2 / R3: table of node event patterns on local counter m0c0
      for (int i = 0; i < 7; i++) begin
         wr(8'h20, {16'h0, VEC[i][39:24]});
         wr(8'h40, 32'h0);
         wr(8'h00, 32'h1);
         pulse({16'h0, VEC[i][23:8]});
         wr(8'h00, 32'h0);
         rd(8'h40, v);
         if (VEC[i][25]) chk($sformatf("R3 vector %0d", i), v, {24'h0, VEC[i][7:0]});
         else            chk($sformatf("R2 vector %0d", i), v, {24'h0, VEC[i][7:0]});
      end

      // R10: events while disabled are ignored
      wr(8'h20, 32'h0);
      wr(8'h40, 32'h0);
      pulse(32'h0101);
      rd(8'h40, v); chk("R10 local held while disabled", v, 0);

      // R6: cycle counter
      wr(8'h02, 32'h0);
      wr(8'h00, 32'h1);
      repeat (10) @(negedge clk);
      rd(8'h02, v); chk("R6 cycle count", v, 10);
      wr(8'h00, 32'h0);
      repeat (5) @(negedge clk);
      rd(8'h02, v); chk("R10 cycle held", v, 12);

      // R4: two wraps into global 2 in one cycle
      wr(8'h20, 32'h0800);
      wr(8'h24, 32'h0800);
      wr(8'h12, 32'h0);
      wr(8'h40, 32'hFFFF);
      wr(8'h44, 32'hFFFF);
      wr(8'h00, 32'h1);
      pulse(32'h0001_0001);
      wr(8'h00, 32'h0);
      rd(8'h12, v); chk("R4 two wraps same cycle", v, 2);
      rd(8'h40, v); chk("R4 local m0c0 wrapped", v, 0);
      rd(8'h44, v); chk("R4 local m1c0 wrapped", v, 0);
      // R4: increment of two crossing zero
      wr(8'h40, 32'hFFFF);
      wr(8'h00, 32'h1);
      pulse(32'h0000_0101);
      wr(8'h00, 32'h0);
      rd(8'h40, v); chk("R4 local crosses zero by two", v, 1);
      rd(8'h12, v); chk("R4 single wrap added", v, 3);

      // R5: global overflow, sticky status, interrupt
      wr(8'h15, 32'hFFFF_FFFF);
      wr(8'h21, 32'h1404);
      wr(8'h41, 32'hFFFF);
      wr(8'h00, 32'h1);
      pulse(32'h0000_0002);
      wr(8'h00, 32'h0);
      rd(8'h15, v); chk("R5 global5 wrapped", v, 0);
      rd(8'h01, v); chk("R5 status set", v, 32'h20);
      chk("R5 irq raised", {31'b0, irq}, 1);
      wr(8'h01, 32'h0);
      rd(8'h01, v); chk("R5 write zero keeps status", v, 32'h20);
      chk("R5 irq kept", {31'b0, irq}, 1);
      wr(8'h01, 32'h20);
      rd(8'h01, v); chk("R5 status cleared", v, 0);
      chk("R5 irq dropped", {31'b0, irq}, 0);

      // R9: clear, then clear colliding with a wrap
      wr(8'h13, 32'h7);
      wr(8'h03, 32'h8);
      rd(8'h13, v); chk("R9 plain clear", v, 0);
      wr(8'h13, 32'h7);
      wr(8'h25, 32'h0C08);
      wr(8'h45, 32'hFFFF);
      wr(8'h00, 32'h1);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 8'h03; reg_wdata = 32'h8;
      node_evt = 32'h0004_0000;
      @(negedge clk);
      reg_we = 1'b0; node_evt = '0;
      wr(8'h00, 32'h0);
      rd(8'h13, v); chk("R9 wrap dropped on clear", v, 0);
      rd(8'h45, v); chk("R9 local still wrapped", v, 0);

      // R7: watchpoint match, mask and direction
      wr(8'h60, 32'hA5C3); wr(8'h61, 32'h000F); wr(8'h62, 32'h0);
      wr(8'h64, 32'h1234); wr(8'h65, 32'h0000); wr(8'h66, 32'h1);
      wr(8'h22, 32'h1C01); wr(8'h23, 32'h1C05);
      wr(8'h42, 32'h0);    wr(8'h43, 32'h0);
      wr(8'h00, 32'h1);
      flit(1'b1, 16'hA5C0, 1'b0, 16'h0);
      flit(1'b1, 16'hA5D3, 1'b0, 16'h0);
      flit(1'b0, 16'hA5C3, 1'b1, 16'hA5C3);
      flit(1'b0, 16'h0,    1'b1, 16'h1234);
      wr(8'h00, 32'h0);
      rd(8'h42, v); chk("R7 wp0 masked match only", v, 1);
      rd(8'h43, v); chk("R7 wp1 download match", v, 1);

      // R8: paired watchpoints
      wr(8'h62, 32'h2); wr(8'h66, 32'h3);
      wr(8'h42, 32'h0); wr(8'h43, 32'h0);
      wr(8'h00, 32'h1);
      flit(1'b1, 16'hA5C3, 1'b0, 16'h0);
      flit(1'b1, 16'hA5C3, 1'b1, 16'h1234);
      flit(1'b0, 16'h0,    1'b1, 16'h1234);
      wr(8'h00, 32'h0);
      rd(8'h42, v); chk("R8 paired credited to wp0", v, 1);
      rd(8'h43, v); chk("R8 paired wp1 silent", v, 0);
      wr(8'h66, 32'h5);
      wr(8'h42, 32'h0); wr(8'h43, 32'h0);
      wr(8'h00, 32'h1);
      flit(1'b1, 16'hA5C3, 1'b1, 16'h1234);
      wr(8'h00, 32'h0);
      rd(8'h42, v); chk("R8 different tags wp0", v, 1);
      rd(8'h43, v); chk("R8 different tags wp1", v, 1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule